// File: doc/BRIEF.md
# Photodiode DC Offset Measurement Unit

This block measures the residual DC level on one of six photodiode sample streams while the laser is switched off. Each stream is first corrected by subtracting a cancellation value that the host has stored for that diode. The result is saturated to the sample width. The corrected stream of the selected diode is summed over a measurement window of programmable length. When the window closes, the block latches the mean of the window as a signed offset word and raises a ready flag.

The host programs the block through a small write port with a strobe, a 2-bit address and a data word. Address 0 selects the diode and address 1 sets the window code. Address 2 is a single location that takes repeated writes: successive writes fill the cancellation values of diodes 0 to 5 in turn. A longer window gives a more accurate mean but needs more samples. The corrected streams of all six diodes are also available as outputs.

Top module: `pdo_offset_meter`

## Requirements
- R1: After a synchronous reset, offset_ready is 0 and offset_word is 0. The diode select is 0, the window code is 0, all six cancellation values are 0 and the write index is 0. A window on diode 0 starts at once.
- R2: A window of code N (N = 0..7, taken from reg_wdata[2:0] of a write to address 1) holds exactly 2^(N+6) samples. Only clock edges with smp_valid high count as samples.
- R3: offset_word is the sum of the window's samples shifted arithmetically right by N+6, so the mean is rounded toward minus infinity. The accumulator does not overflow, even for a full window of code 7 at -2048 or +2047.
- R4: offset_ready rises at the clock edge that takes the last sample of the window. Until the next restart, offset_ready stays high and offset_word does not change, whatever samples arrive.
- R5: A write to address 0 with a value from 0 to 5 makes that diode the selected one. It also restarts the window and clears both offset_ready and offset_word. A write to address 0 with a value of 6 or more is ignored: the selection, the window and the result are all kept.
- R6: A write to address 1 sets the window code and restarts the window. It also clears offset_ready and offset_word.
- R7: A write to address 2 stores reg_wdata as the signed cancellation value of the diode named by the write index. The index then advances, and it wraps from 5 back to 0.
- R8: A write to address 0, 1 or 3 sets the write index back to 0. A write to address 3 has no other effect: it neither restarts the window nor clears the result.
- R9: Each corr_bus lane i (bits 12i+11 to 12i) shows the sample on smp_bus lane i minus the cancellation value of diode i, saturated to the range -2048 to 2047. This path is combinational.
- R10: The window sums the corrected stream of the selected diode. The raw samples and the other diodes' streams have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe for all six lanes |
| smp_bus | input | 72 | Six signed 12-bit samples, lane i at bits 12i+11 to 12i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 diode select, 1 window code, 2 cancellation values, 3 spare |
| reg_wdata | input | 12 | Write data |
| corr_bus | output | 72 | Six corrected, saturated samples in the same layout as smp_bus |
| offset_word | output | 12 | Latched signed mean of the last window |
| offset_ready | output | 1 | High once a window has completed |

## Verification
A constant stream checks the window length and when ready rises. A stream that alternates between two negative values, with the strobe high only every other cycle, checks that idle cycles are not counted and that the mean rounds down rather than toward zero. Full-scale streams at both ends over the longest window expose any accumulator overflow. Unselected lanes carry distinct values, and non-zero cancellation values are used, to show that only the corrected selected lane is measured. Extreme pairs of sample and cancellation value drive the saturation in both directions.

// File: rtl/pdo_pkg.sv
package pdo_pkg;

    localparam int PDO_NUM_DIODES = 6;
    localparam int PDO_SAMPLE_W   = 12;
    localparam int PDO_CODE_W     = 3;
    localparam int PDO_MIN_SHIFT  = 6;

    typedef enum logic [1:0] {
        ADDR_SELECT = 2'd0,
        ADDR_WINDOW = 2'd1,
        ADDR_CANCEL = 2'd2,
        ADDR_SPARE  = 2'd3
    } pdo_addr_e;

    // the register side's request to the measuring side
    typedef struct packed {
        logic restart;
        logic cancel_we;
    } pdo_ctrl_t;

    // shift that turns a window sum into a mean
    function automatic int win_shift(input int code, input int min_shift);
        return code + min_shift;
    endfunction

    // accumulator width needed for the longest window
    function automatic int acc_width(input int sample_w, input int code_w, input int min_shift);
        return sample_w + min_shift + (1 << code_w) - 1;
    endfunction

endpackage

// File: rtl/pdo_regfile.sv
module pdo_regfile
    import pdo_pkg::*;
#(
    parameter int NUM_DIODES = PDO_NUM_DIODES,
    parameter int SAMPLE_W   = PDO_SAMPLE_W,
    parameter int CODE_W     = PDO_CODE_W,
    localparam int IDX_W     = $clog2(NUM_DIODES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [SAMPLE_W-1:0] reg_wdata,
    output logic [IDX_W-1:0]    sel_q,
    output logic [CODE_W-1:0]   code_q,
    output logic [IDX_W-1:0]    wr_idx,
    output pdo_ctrl_t           ctrl
);

    pdo_addr_e addr;
    logic      sel_ok;

    assign addr   = pdo_addr_e'(reg_addr);
    assign sel_ok = reg_wdata < SAMPLE_W'(NUM_DIODES);

    always_comb begin
        ctrl.restart   = reg_wr && ((addr == ADDR_SELECT && sel_ok) || addr == ADDR_WINDOW);
        ctrl.cancel_we = reg_wr && addr == ADDR_CANCEL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            code_q <= '0;
            wr_idx <= '0;
        end else if (reg_wr) begin
            case (addr)
                ADDR_SELECT: begin
                    if (sel_ok) sel_q <= reg_wdata[IDX_W-1:0];
                    wr_idx <= '0;
                end
                ADDR_WINDOW: begin
                    code_q <= reg_wdata[CODE_W-1:0];
                    wr_idx <= '0;
                end
                ADDR_CANCEL: begin
                    if (wr_idx == IDX_W'(NUM_DIODES - 1)) wr_idx <= '0;
                    else                                  wr_idx <= wr_idx + 1'b1;
                end
                default: wr_idx <= '0;
            endcase
        end
    end

    a_r7_index_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_idx < IDX_W'(NUM_DIODES));

    a_r8_index_cleared: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && addr != ADDR_CANCEL) |=> wr_idx == '0);

    a_r5_bad_select_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && addr == ADDR_SELECT && !sel_ok) |=> $stable(sel_q));

endmodule

// File: rtl/pdo_cancel_bank.sv
module pdo_cancel_bank
    import pdo_pkg::*;
#(
    parameter int NUM_DIODES = PDO_NUM_DIODES,
    parameter int SAMPLE_W   = PDO_SAMPLE_W,
    localparam int IDX_W     = $clog2(NUM_DIODES),
    localparam int BUS_W     = NUM_DIODES * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [BUS_W-1:0]    smp_bus,
    output logic [BUS_W-1:0]    corr_bus
);

    logic signed [SAMPLE_W-1:0] cancel_q [NUM_DIODES];

    for (genvar g = 0; g < NUM_DIODES; g++) begin : g_lane
        logic signed [SAMPLE_W-1:0] raw;
        logic signed [SAMPLE_W:0]   diff;

        always_ff @(posedge clk) begin
            if (rst)                                cancel_q[g] <= '0;
            else if (we && idx == IDX_W'(g))        cancel_q[g] <= wdata;
        end

        assign raw  = smp_bus[g*SAMPLE_W +: SAMPLE_W];
        assign diff = {raw[SAMPLE_W-1], raw} - {cancel_q[g][SAMPLE_W-1], cancel_q[g]};

        always_comb begin
            if (diff[SAMPLE_W] != diff[SAMPLE_W-1])
                corr_bus[g*SAMPLE_W +: SAMPLE_W] = diff[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                                                  : {1'b0, {(SAMPLE_W-1){1'b1}}};
            else
                corr_bus[g*SAMPLE_W +: SAMPLE_W] = diff[SAMPLE_W-1:0];
        end
    end

    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> cancel_q[$past(idx)] == $past(wdata));

endmodule

// File: rtl/pdo_window_acc.sv
module pdo_window_acc
    import pdo_pkg::*;
#(
    parameter int NUM_DIODES = PDO_NUM_DIODES,
    parameter int SAMPLE_W   = PDO_SAMPLE_W,
    parameter int CODE_W     = PDO_CODE_W,
    parameter int MIN_SHIFT  = PDO_MIN_SHIFT,
    localparam int IDX_W     = $clog2(NUM_DIODES),
    localparam int BUS_W     = NUM_DIODES * SAMPLE_W,
    localparam int ACC_W     = acc_width(SAMPLE_W, CODE_W, MIN_SHIFT),
    localparam int CNT_W     = MIN_SHIFT + (1 << CODE_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                smp_valid,
    input  logic [IDX_W-1:0]    sel,
    input  logic [CODE_W-1:0]   code,
    input  logic [BUS_W-1:0]    corr_bus,
    output logic [SAMPLE_W-1:0] result,
    output logic                ready
);

    logic                    running;
    logic [CNT_W-1:0]        cnt;
    logic [CNT_W-1:0]        win_len;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] acc_sum;
    logic signed [ACC_W-1:0] mean_full;
    logic [SAMPLE_W-1:0]     pick;
    logic                    last;
    int                      shamt;

    assign shamt     = win_shift(int'(code), MIN_SHIFT);
    assign win_len   = CNT_W'(1) << shamt;
    assign pick      = corr_bus[int'(sel)*SAMPLE_W +: SAMPLE_W];
    assign acc_sum   = acc + {{(ACC_W-SAMPLE_W){pick[SAMPLE_W-1]}}, pick};
    assign mean_full = acc_sum >>> shamt;
    assign last      = cnt == win_len - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            running <= 1'b1;
            cnt     <= '0;
            acc     <= '0;
            ready   <= 1'b0;
            result  <= '0;
        end else if (running && smp_valid) begin
            if (last) begin
                result  <= mean_full[SAMPLE_W-1:0];
                ready   <= 1'b1;
                running <= 1'b0;
                cnt     <= '0;
                acc     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                acc <= acc_sum;
            end
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < win_len);

    a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!ready && result == '0));

    a_r4_result_held: assert property (@(posedge clk) disable iff (rst)
        (ready && !restart) |=> (ready && $stable(result)));

    a_r4_idle_when_done: assert property (@(posedge clk) disable iff (rst)
        ready |-> !running);

endmodule

// File: rtl/pdo_offset_meter.sv
module pdo_offset_meter
    import pdo_pkg::*;
#(
    parameter int NUM_DIODES = PDO_NUM_DIODES,
    parameter int SAMPLE_W   = PDO_SAMPLE_W,
    parameter int CODE_W     = PDO_CODE_W,
    parameter int MIN_SHIFT  = PDO_MIN_SHIFT,
    localparam int IDX_W     = $clog2(NUM_DIODES),
    localparam int BUS_W     = NUM_DIODES * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [BUS_W-1:0]    smp_bus,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [SAMPLE_W-1:0] reg_wdata,
    output logic [BUS_W-1:0]    corr_bus,
    output logic [SAMPLE_W-1:0] offset_word,
    output logic                offset_ready
);

    logic [IDX_W-1:0]  sel_q;
    logic [IDX_W-1:0]  wr_idx;
    logic [CODE_W-1:0] code_q;
    pdo_ctrl_t         ctrl;

    pdo_regfile #(
        .NUM_DIODES(NUM_DIODES), .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)
    ) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sel_q(sel_q), .code_q(code_q),
        .wr_idx(wr_idx), .ctrl(ctrl)
    );

    pdo_cancel_bank #(
        .NUM_DIODES(NUM_DIODES), .SAMPLE_W(SAMPLE_W)
    ) u_cancel (
        .clk(clk), .rst(rst), .we(ctrl.cancel_we), .idx(wr_idx),
        .wdata(reg_wdata), .smp_bus(smp_bus), .corr_bus(corr_bus)
    );

    pdo_window_acc #(
        .NUM_DIODES(NUM_DIODES), .SAMPLE_W(SAMPLE_W),
        .CODE_W(CODE_W), .MIN_SHIFT(MIN_SHIFT)
    ) u_win (
        .clk(clk), .rst(rst), .restart(ctrl.restart), .smp_valid(smp_valid),
        .sel(sel_q), .code(code_q), .corr_bus(corr_bus),
        .result(offset_word), .ready(offset_ready)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!offset_ready && offset_word == '0));

endmodule

// File: tb/pdo_offset_meter_tb.sv
module pdo_offset_meter_tb;

    localparam int N = 6;
    localparam int W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [N*W-1:0]   smp_bus;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [W-1:0]     reg_wdata = '0;
    logic [N*W-1:0]   corr_bus;
    logic [W-1:0]     offset_word;
    logic             offset_ready;

    logic signed [W-1:0] smp [N];
    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int cur_sel = 0;

    always #5 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) smp_bus[i*W +: W] = smp[i];

    pdo_offset_meter u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_bus(smp_bus),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .corr_bus(corr_bus), .offset_word(offset_word), .offset_ready(offset_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int offs();
        return int'($signed(offset_word));
    endfunction

    function automatic int corr(input int i);
        return int'($signed(corr_bus[i*W +: W]));
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'(addr); reg_wdata = W'(data);
        @(negedge clk);
        reg_wr = 1'b0;
        if (addr == 0 && data >= 0 && data < N) cur_sel = data;
    endtask

    function automatic void set_lanes(input int v, input int other);
        for (int i = 0; i < N; i++) smp[i] = W'((i == cur_sel) ? v : other);
    endfunction

    // feeds n samples: selected lane alternates a/b, others hold other
    task automatic feed(input int n, input int a, input int b, input int other,
                        input bit gap, output int ready_before);
        ready_before = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == n - 1) ready_before = int'(offset_ready);
            set_lanes((k % 2 == 0) ? a : b, other);
            smp_valid = 1'b1;
            if (gap) begin
                @(negedge clk);
                smp_valid = 1'b0;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", int'(offset_ready), 0);
        chk("R1 offset after reset", offs(), 0);
        set_lanes(123, 123);
        #1;
        chk("R1 cancel lane0 zero", corr(0), 123);
        chk("R1 cancel lane5 zero", corr(5), 123);
    endtask

    task automatic t_const_window();
        int rb;
        wr(0, 0); wr(1, 0);
        feed(63, -100, -100, 900, 0, rb);
        chk("R2 not ready after 63 samples", int'(offset_ready), 0);
        feed(1, -100, -100, 900, 0, rb);
        chk("R4 ready after 64 samples", int'(offset_ready), 1);
        chk("R3 mean of constant", offs(), -100);
    endtask

    task automatic t_hold();
        int rb;
        feed(20, 700, 700, 700, 0, rb);
        chk("R4 ready held", int'(offset_ready), 1);
        chk("R4 offset held", offs(), -100);
    endtask

    task automatic t_gapped_floor();
        int rb;
        wr(0, 2); wr(1, 1);
        feed(128, -3, -4, 1500, 1, rb);
        chk("R2 ready low before last gapped sample", rb, 0);
        chk("R2 ready after 128 gapped samples", int'(offset_ready), 1);
        chk("R3 mean rounds down", offs(), -4);
    endtask

    task automatic t_full_scale();
        int rb;
        wr(0, 5); wr(1, 7);
        feed(8192, -2048, -2048, 0, 0, rb);
        chk("R2 ready low before sample 8192", rb, 0);
        chk("R3 full negative window", offs(), -2048);
        wr(1, 7);
        feed(8192, 2047, 2047, 0, 0, rb);
        chk("R3 full positive window", offs(), 2047);
    endtask

    task automatic t_restart();
        int rb;
        wr(0, 3); wr(1, 0);
        feed(30, 500, 500, 0, 0, rb);
        wr(0, 4);
        chk("R5 select clears ready", int'(offset_ready), 0);
        chk("R5 select clears offset", offs(), 0);
        feed(64, 10, 10, -700, 0, rb);
        chk("R5 restart discards old samples", offs(), 10);
        wr(1, 0);
        chk("R6 window write clears ready", int'(offset_ready), 0);
        chk("R6 window write clears offset", offs(), 0);
        feed(64, -9, -9, 0, 0, rb);
        chk("R6 new window result", offs(), -9);
    endtask

    task automatic t_cancel_seq();
        wr(3, 0);
        for (int i = 1; i <= 7; i++) wr(2, 11 * i);
        set_lanes(100, 100);
        #1;
        chk("R7 wrap to diode0", corr(0), 23);
        chk("R7 diode1", corr(1), 78);
        chk("R7 diode3", corr(3), 56);
        chk("R7 diode5", corr(5), 34);
        wr(2, 1000);
        #1;
        chk("R7 index continues at diode1", corr(1), -900);
        wr(3, 0);
        wr(2, -5);
        #1;
        chk("R8 spare write resets index", corr(0), 105);
        chk("R8 diode1 untouched", corr(1), -900);
    endtask

    task automatic t_saturate();
        wr(3, 0);
        wr(2, 2047); wr(2, -2048);
        for (int i = 2; i < N; i++) wr(2, 0);
        smp[0] = -12'sd2048; smp[1] = 12'sd2047; smp[2] = 12'sd5;
        #1;
        chk("R9 negative saturation", corr(0), -2048);
        chk("R9 positive saturation", corr(1), 2047);
        chk("R9 plain lane", corr(2), 5);
    endtask

    task automatic t_measure_corrected();
        int rb;
        wr(3, 0);
        wr(2, 0); wr(2, 50);
        for (int i = 2; i < N; i++) wr(2, 0);
        wr(0, 1); wr(1, 0);
        feed(64, 80, 80, 80, 0, rb);
        chk("R10 measures corrected lane", offs(), 30);
        wr(0, 6);
        chk("R5 bad select keeps ready", int'(offset_ready), 1);
        chk("R5 bad select keeps offset", offs(), 30);
        wr(3, 0);
        chk("R8 spare write keeps ready", int'(offset_ready), 1);
        wr(0, 1);
        chk("R5 good select clears ready", int'(offset_ready), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) smp[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_const_window();
        t_hold();
        t_gapped_floor();
        t_full_scale();
        t_restart();
        t_cancel_seq();
        t_saturate();
        t_measure_corrected();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule